// File: doc/BRIEF.md
# UART Hardware Flow Control Unit

This block handles modem-style handshaking for a UART whose receive FIFO holds 64 bytes. On the transmit side, the clear-to-send pin (CTS) controls whether the transmitter may start its next character. A level that is HIGH at the pin blocks the start of the next character, but only while CTS gating is enabled. The pin passes through a two-flop synchronizer before the block uses it. The block only qualifies the transmitter's "ready to start character" strobe. A character that is already on the line is never cut short.

On the receive side, the block drives the request-to-send pin (RTS) from the receive FIFO fill level, but only while RTS control is enabled. An 8-bit threshold register holds two 4-bit fields. Each field is multiplied by four to give a level from 0 to 60 entries:
- The low nibble sets the halt level. RTS goes HIGH when the fill count reaches it.
- The high nibble sets the resume level. RTS goes LOW when the fill count falls to it.
- When the fill count lies strictly between the two levels, RTS keeps its value, which gives hysteresis.

While RTS control is disabled, RTS follows a software-controlled bit. Both enables arrive as plain inputs, so both features are off when the enable inputs are held low.

Top module: `uart_flow_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `rts_out` is 0 and the synchronized CTS level reads 0. With `cts_en`=1 and `tx_start_req`=1 in that window, `tx_go` is therefore 1 whatever the pin level.
- R2: With `cts_en`=0, `tx_go` equals `tx_start_req` in the same cycle, whatever the CTS pin level.
- R3: With `cts_en`=1 and a synchronized CTS level of 1 (HIGH means stop), `tx_go` is 0 even when `tx_start_req` is 1. With a synchronized level of 0, `tx_go` equals `tx_start_req`.
- R4: A change on `cts_in` reaches `tx_go` after the second rising clock edge that samples it, and not after the first.
- R5: With `rts_en`=1, the clock edge that samples `rx_count` >= 4*`rts_thr[3:0]` sets `rts_out` to 1. A halt field of 0 therefore keeps RTS HIGH.
- R6: With `rts_en`=1, the clock edge that samples `rx_count` <= 4*`rts_thr[7:4]` while `rx_count` is below the halt level clears `rts_out` to 0.
- R7: With `rts_en`=1, a count strictly between the resume and halt levels leaves `rts_out` unchanged.
- R8: When a count satisfies both the halt and the resume conditions (resume level >= halt level), the halt condition wins and `rts_out` becomes 1.
- R9: With `rts_en`=0, `rts_out` takes the value of `rts_sw` at the next clock edge. While `rts_en`=1, `rts_sw` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cts_en | input | 1 | Enables gating of character starts by CTS |
| rts_en | input | 1 | Enables threshold-driven RTS |
| rts_sw | input | 1 | Software RTS level used while RTS control is off |
| rts_thr | input | 8 | [3:0] halt field, [7:4] resume field, each in units of 4 entries |
| rx_count | input | 7 | Current receive FIFO fill count, 0 to 64 |
| cts_in | input | 1 | Raw CTS pin, asynchronous, HIGH = stop |
| tx_start_req | input | 1 | Transmitter strobe: ready to start a character |
| tx_go | output | 1 | Start strobe permitted by flow control |
| rts_out | output | 1 | RTS pin level |

## Verification
On the receive side, the halt and resume conditions can be true in the same cycle. This happens when the resume field is programmed at or above the halt field. The bench provokes it with equal fields and with a zero halt field, and it expects RTS to go HIGH, as R8 gives priority to halt. On the transmit side, a start strobe can arrive in the same cycle that the synchronized CTS changes. The bench holds the strobe high across a CTS transition and checks `tx_go` on the cycle after each of the two synchronizer edges.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
  localparam int FIFO_DEPTH = 64;
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
  localparam int FIELD_W    = 4;
  localparam int THR_W      = 2 * FIELD_W;
  localparam int SCALE_SH   = 2;
  localparam int SYNC_STAGES = 2;

  // Threshold field to FIFO level: field times four
  function automatic logic [CNT_W-1:0] field_to_level(input logic [FIELD_W-1:0] f);
    return CNT_W'(f) << SCALE_SH;
  endfunction

  // Halt field sits in the low nibble, resume in the high nibble
  function automatic logic [FIELD_W-1:0] halt_field(input logic [THR_W-1:0] t);
    return t[FIELD_W-1:0];
  endfunction

  function automatic logic [FIELD_W-1:0] resume_field(input logic [THR_W-1:0] t);
    return t[THR_W-1:FIELD_W];
  endfunction
endpackage

// File: rtl/fc_cts_sync.sv
module fc_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[gi] <= 1'b0;
          else        chain[gi] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[gi] <= 1'b0;
          else        chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];

  // Cycles since reset, saturating, for assertion arming
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_SYNC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd0) |-> !q_sync);  // R1
  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (STAGES == 2 && age >= 2'd2) |-> (q_sync == $past(d_async, 2)));  // R4
endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate (
  input  logic cts_en,
  input  logic cts_level,
  input  logic start_req,
  output logic start_blocked,
  output logic tx_go
);
  // Only the start of a new character is qualified; nothing aborts one in flight
  assign start_blocked = cts_en & cts_level;
  assign tx_go         = start_req & ~start_blocked;
endmodule

// File: rtl/fc_rts_ctrl.sv
module fc_rts_ctrl
  import uart_fc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sw_level,
  input  logic [THR_W-1:0] thr,
  input  logic [CNT_W-1:0] count,
  output logic             halt_hit,
  output logic             resume_hit,
  output logic             rts_q
);
  logic [CNT_W-1:0] halt_lvl;
  logic [CNT_W-1:0] resume_lvl;
  logic             rts_d;

  assign halt_lvl   = field_to_level(halt_field(thr));
  assign resume_lvl = field_to_level(resume_field(thr));
  assign halt_hit   = (count >= halt_lvl);
  assign resume_hit = (count <= resume_lvl);

  always_comb begin
    if (!en)             rts_d = sw_level;
    else if (halt_hit)   rts_d = 1'b1;   // halt has priority
    else if (resume_hit) rts_d = 1'b0;
    else                 rts_d = rts_q;  // hysteresis band
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts_q <= 1'b0;
    else        rts_q <= rts_d;
  end

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_RTS_RESET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !rts_q);  // R1
  AST_RTS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(en) && ($past(count) >= {1'b0, $past(thr[3:0]), 2'b00})) |-> rts_q);  // R5
  AST_RTS_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(en) && ($past(count) <= {1'b0, $past(thr[7:4]), 2'b00})
     && !$past(halt_hit)) |-> !rts_q);  // R6
  AST_RTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(en) && !$past(halt_hit) && !$past(resume_hit)) |-> $stable(rts_q));  // R7
  AST_RTS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(en) && $past(halt_hit) && $past(resume_hit)) |-> rts_q);  // R8
  AST_RTS_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(en)) |-> (rts_q == $past(sw_level)));  // R9
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
  import uart_fc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cts_en,
  input  logic             rts_en,
  input  logic             rts_sw,
  input  logic [THR_W-1:0] rts_thr,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             cts_in,
  input  logic             tx_start_req,
  output logic             tx_go,
  output logic             rts_out
);
  logic cts_level;
  logic start_blocked;
  logic halt_hit;
  logic resume_hit;

  fc_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (cts_in),
    .q_sync  (cts_level)
  );

  fc_tx_gate u_gate (
    .cts_en        (cts_en),
    .cts_level     (cts_level),
    .start_req     (tx_start_req),
    .start_blocked (start_blocked),
    .tx_go         (tx_go)
  );

  fc_rts_ctrl u_rts (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (rts_en),
    .sw_level   (rts_sw),
    .thr        (rts_thr),
    .count      (rx_count),
    .halt_hit   (halt_hit),
    .resume_hit (resume_hit),
    .rts_q      (rts_out)
  );

  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  AST_CTS_STOPS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd2 && cts_en && $past(cts_in, 2)) |-> !tx_go);  // R3
  AST_CTS_LOW_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd2 && !$past(cts_in, 2) && tx_start_req) |-> tx_go);  // R3
  AST_NO_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cts_en && tx_start_req) |-> !start_blocked);  // R2
endmodule

// File: tb/uart_flow_ctrl_bench.sv
module uart_flow_ctrl_bench;
  import uart_fc_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cts_en = 1'b0, rts_en = 1'b0, rts_sw = 1'b0;
  logic [THR_W-1:0] rts_thr = '0;
  logic [CNT_W-1:0] rx_count = '0;
  logic cts_in = 1'b0, tx_start_req = 1'b0;
  logic tx_go, rts_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_flow_ctrl u_uart_flow_ctrl (
    .clk(clk), .rst_n(rst_n), .cts_en(cts_en), .rts_en(rts_en), .rts_sw(rts_sw),
    .rts_thr(rts_thr), .rx_count(rx_count), .cts_in(cts_in),
    .tx_start_req(tx_start_req), .tx_go(tx_go), .rts_out(rts_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // {rts_en, rts_sw, rts_thr, rx_count, expected rts_out}; thr 0x28: resume 8, halt 32
  localparam int NV = 14;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'h28, 7'd0,  1'b1},  // R9
    {1'b0, 1'b0, 8'h28, 7'd40, 1'b0},  // R9
    {1'b1, 1'b0, 8'h28, 7'd10, 1'b0},  // R7
    {1'b1, 1'b1, 8'h28, 7'd31, 1'b0},  // R7 / R9 sw ignored
    {1'b1, 1'b0, 8'h28, 7'd32, 1'b1},  // R5
    {1'b1, 1'b0, 8'h28, 7'd20, 1'b1},  // R7
    {1'b1, 1'b0, 8'h28, 7'd9,  1'b1},  // R7
    {1'b1, 1'b0, 8'h28, 7'd8,  1'b0},  // R6
    {1'b1, 1'b0, 8'h28, 7'd31, 1'b0},  // R7
    {1'b1, 1'b0, 8'h28, 7'd64, 1'b1},  // R5
    {1'b1, 1'b0, 8'h44, 7'd16, 1'b1},  // R8
    {1'b1, 1'b0, 8'h80, 7'd0,  1'b1},  // R8, R5 halt field 0
    {1'b1, 1'b1, 8'h3F, 7'd12, 1'b0},  // R6
    {1'b0, 1'b1, 8'h3F, 7'd60, 1'b1}   // R9
  };

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state, pin HIGH but synchronizer cleared
    cts_en = 1'b1; tx_start_req = 1'b1; cts_in = 1'b1; rts_sw = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 rts in reset", rts_out, 1'b0);
    check("R1 tx_go in reset", tx_go, 1'b1);
    rst_n = 1'b1;
    check("R1 tx_go after release", tx_go, 1'b1);
    @(negedge clk);
    check("R4 one edge, still passing", tx_go, 1'b1);
    @(negedge clk);
    check("R3 blocked after two edges", tx_go, 1'b0);
    check("R9 soft rts follows", rts_out, 1'b1);

    // R2: gating off passes strobe through
    cts_en = 1'b0;
    #1 check("R2 gate off passes", tx_go, 1'b1);
    tx_start_req = 1'b0;
    #1 check("R2 no strobe no go", tx_go, 1'b0);
    cts_en = 1'b1; tx_start_req = 1'b1;
    #1 check("R3 blocked again", tx_go, 1'b0);

    // R4: release CTS with strobe held
    @(negedge clk); cts_in = 1'b0;
    @(negedge clk);
    check("R4 release after one edge", tx_go, 1'b0);
    @(negedge clk);
    check("R4 release after two edges", tx_go, 1'b1);
    check("R3 low level passes", tx_go, 1'b1);

    // RTS table walk
    for (int i = 0; i < NV; i++) begin
      {rts_en, rts_sw, rts_thr, rx_count} = VEC[i][17:1];
      @(negedge clk);
      check($sformatf("R5-table row %0d (R5 R6 R7 R8 R9)", i), rts_out, VEC[i][0]);
    end

    // R9: sw ignored while enabled, between levels keeps state
    rts_en = 1'b1; rts_thr = 8'h28; rx_count = 7'd40;
    @(negedge clk);
    rts_sw = 1'b0; rx_count = 7'd20;
    @(negedge clk);
    check("R9 sw ignored while enabled", rts_out, 1'b1);
    rts_sw = 1'b1; rx_count = 7'd4;
    @(negedge clk);
    check("R6 below resume", rts_out, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule